// File: doc/BRIEF.md
# Serial Audio Transmit Clocking Unit

This block produces the bit clock and frame sync for one serial audio transmit lane and shifts one parallel word out, most significant bit first, in each frame. Frames follow each other without gaps, and each frame is `WORD_W` bit periods long. Frame sync is active for the first bit period of every frame. The whole unit runs on a single high-frequency master clock `clk`.

The bit clock has two possible sources. The internal generator divides the master clock by a 4-bit setting. When it is selected, the generated clock is driven onto the bit clock pin and the pin's output enable is raised. When it is not selected, the pin is an input, and an external bit clock arriving on it is synchronised and used instead. Both sources are turned into launch and capture strobes inside the `clk` domain.

Polarity controls pick the bit clock edge on which data and frame sync are launched, the active level of frame sync, and the phase of the generated clock. A synchronous-mode input forwards the capture strobe to the receive shifter, so that the receive path can share the transmit clock. Host software writes a word into a holding register with a one-cycle strobe. The word is sent in the next frame.

Top module: `aud_tx_clk`

## Requirements
- R1: With `clkDirInt`=1, the bit clock on `sckOut` toggles every `divSel`+1 master cycles. Its full period is therefore 2*(`divSel`+1) master cycles, for every value of `divSel` from 0 to 15.
- R2: With `bitClkPol`=0, `serialOut` and `frameSync` change after rising bit clock edges and are valid on the falling edges. With `bitClkPol`=1, the roles of the two edges are swapped.
- R3: With `fsPol`=0, `frameSync` is high for exactly the first bit period of a frame and low otherwise. With `fsPol`=1, it is low for that bit period and high otherwise.
- R4: Each frame carries `WORD_W` bits, most significant bit first, and the next frame starts on the launch edge that follows the last bit.
- R5: With `clkDirInt`=1, `sckOe` is 1 and `sckOut` carries the generated clock. With `clkDirInt`=0, `sckOe` is 0, `sckOut` is held at 0, and frames are timed by the clock on `sckIn`.
- R6: `hfClkPol`=1 inverts the generated clock. For the first `divSel`+1 master cycles after reset with `clkDirInt`=1, `sckOut` equals `hfClkPol`.
- R7: With `syncMode`=1, `rxShiftEn` pulses for one master cycle on every capture edge. With `syncMode`=0, it stays at 0. A change of `syncMode` applies at once.
- R8: Before the first frame starts, the divider, direction and polarity inputs take effect one cycle after they change. After that, a change to them takes effect only at the next frame start. In between, `sckOe` and the `frameSync` level keep their previous behaviour.
- R9: A word written with `txLoad` during a frame is sent in the next frame. A frame for which no new word was written sends all zeros, and `serialOut` is 0 until a loaded word is sent.
- R10: While `rstN` is low, `sckOe`, `sckOut`, `serialOut` and `frameSync` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | High-frequency master clock |
| rstN | input | 1 | Asynchronous active-low reset |
| divSel | input | 4 | Half-period of the generated bit clock, minus one, in master cycles |
| clkDirInt | input | 1 | 1: internal generator drives the pin; 0: bit clock is taken from `sckIn` |
| bitClkPol | input | 1 | 0: launch on rising and capture on falling; 1: the reverse |
| fsPol | input | 1 | 0: frame sync active high; 1: active low |
| hfClkPol | input | 1 | Inverts the generated clock |
| syncMode | input | 1 | 1: forward capture strobes to the receive shifter |
| txData | input | WORD_W | Parallel word to transmit |
| txLoad | input | 1 | One-cycle strobe that writes `txData` into the holding register |
| sckIn | input | 1 | External bit clock from the pin |
| sckOut | output | 1 | Generated bit clock to the pin |
| sckOe | output | 1 | Output enable of the bit clock pin |
| frameSync | output | 1 | Frame sync |
| serialOut | output | 1 | Serial data |
| rxShiftEn | output | 1 | Capture strobe for the receive shifter in synchronous mode |

## Verification
The hardest situation to reach from the ports is a change of a control input in the middle of a frame, because the new value must not show until the frame boundary. The bench's serial receiver model detects a frame start. A couple of bit periods later, the bench flips the frame sync polarity and switches the clock direction to external while leaving `sckIn` idle. This freezes the next frame on its first bit, so the newly applied polarity and pin direction can be read as static levels. Starting the external clock afterwards then releases frame sync to its new inactive level.

// File: rtl/aud_tx_pkg.sv
package aud_tx_pkg;
  localparam int DIV_W = 4;

  typedef struct packed {
    logic [DIV_W-1:0] div;
    logic             dirInt;
    logic             clkPol;
    logic             fsPol;
    logic             hfPol;
  } txCfg_t;

  typedef struct packed {
    logic launch;
    logic capture;
    logic frameStart;
  } txStrobe_t;
endpackage

// File: rtl/aud_tx_ctrl.sv
module aud_tx_ctrl
  import aud_tx_pkg::*;
#(
  parameter int WORD_W      = 24,
  parameter int SYNC_STAGES = 2
) (
  input  logic      clk,
  input  logic      rstN,
  input  txCfg_t    cfgIn,
  input  logic      syncMode,
  input  logic      sckIn,
  output txStrobe_t strb,
  output txCfg_t    cfgAct,
  output logic      sckOut,
  output logic      sckOe,
  output logic      rxShiftEn
);
  localparam int BIT_W = (WORD_W > 1) ? $clog2(WORD_W) : 1;
  localparam logic [BIT_W-1:0] LAST_BIT = BIT_W'(WORD_W - 1);

  txCfg_t             act;
  logic               started;
  logic [BIT_W-1:0]   bitIdx;
  logic [DIV_W-1:0]   divCnt;
  logic               genPh;
  logic               genClk;
  logic               extClk;
  logic               bclk;
  logic               bclkQ;
  logic               edgeMask;
  logic               rise;
  logic               fall;
  logic               launch;
  logic               capture;
  logic               frameStart;
  logic               loadCfg;
  logic               srcChange;

  // external clock synchroniser, depth chosen by parameter
  generate
    if (SYNC_STAGES > 1) begin : g_syncChain
      logic [SYNC_STAGES-1:0] syncQ;
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) syncQ <= '0;
        else       syncQ <= {syncQ[SYNC_STAGES-2:0], sckIn};
      end
      assign extClk = syncQ[SYNC_STAGES-1];
    end else begin : g_syncSingle
      logic syncQ;
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) syncQ <= 1'b0;
        else       syncQ <= sckIn;
      end
      assign extClk = syncQ;
    end
  endgenerate

  // configuration follows the inputs until the first frame, then only at frame starts
  assign loadCfg   = !started || frameStart;
  assign srcChange = loadCfg && ((cfgIn.dirInt != act.dirInt) || (cfgIn.hfPol != act.hfPol));

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)        act <= '0;
    else if (loadCfg) act <= cfgIn;
  end

  // internal bit clock generator
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      divCnt <= '0;
      genPh  <= 1'b0;
    end else if (!act.dirInt) begin
      divCnt <= '0;
      genPh  <= 1'b0;
    end else if (divCnt >= act.div) begin
      divCnt <= '0;
      genPh  <= ~genPh;
    end else begin
      divCnt <= divCnt + 1'b1;
    end
  end

  assign genClk = genPh ^ act.hfPol;
  assign bclk   = act.dirInt ? genClk : extClk;

  // edge detection; a source switch must not look like a clock edge
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      bclkQ    <= 1'b0;
      edgeMask <= 1'b0;
    end else begin
      bclkQ    <= bclk;
      edgeMask <= srcChange;
    end
  end

  assign rise       = bclk && !bclkQ && !edgeMask;
  assign fall       = !bclk && bclkQ && !edgeMask;
  assign launch     = act.clkPol ? fall : rise;
  assign capture    = act.clkPol ? rise : fall;
  assign frameStart = launch && (!started || (bitIdx == LAST_BIT));

  // word-length counter
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      started <= 1'b0;
      bitIdx  <= '0;
    end else if (launch) begin
      started <= 1'b1;
      bitIdx  <= frameStart ? '0 : bitIdx + 1'b1;
    end
  end

  assign strb.launch     = launch;
  assign strb.capture    = capture;
  assign strb.frameStart = frameStart;
  assign cfgAct          = act;
  assign sckOe           = act.dirInt;
  assign sckOut          = act.dirInt && genClk;
  assign rxShiftEn       = syncMode && capture;

  AST_EDGE_EXCL: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({launch, capture}));  // R2

  AST_CFG_FRAME_ONLY: assert property (@(posedge clk) disable iff (!rstN)
    (started && !frameStart) |=> $stable(act));  // R8

  AST_DIV_TOGGLE: assert property (@(posedge clk) disable iff (!rstN)
    ($past(act.dirInt) && (genPh != $past(genPh))) |-> ($past(divCnt) >= $past(act.div)));  // R1
endmodule

// File: rtl/aud_tx_dpath.sv
module aud_tx_dpath
  import aud_tx_pkg::*;
#(
  parameter int WORD_W = 24
) (
  input  logic              clk,
  input  logic              rstN,
  input  txStrobe_t         strb,
  input  logic              fsPolAct,
  input  logic [WORD_W-1:0] txData,
  input  logic              txLoad,
  output logic              frameSync,
  output logic              serialOut
);
  logic [WORD_W-1:0] holdWord;
  logic [WORD_W-1:0] shReg;
  logic              holdValid;
  logic              fsActive;

  // holding register: a word is consumed by the frame start after it is written
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      holdWord  <= '0;
      holdValid <= 1'b0;
    end else if (txLoad) begin
      holdWord  <= txData;
      holdValid <= 1'b1;
    end else if (strb.frameStart) begin
      holdValid <= 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      shReg    <= '0;
      fsActive <= 1'b0;
    end else if (strb.launch) begin
      fsActive <= strb.frameStart;
      if (strb.frameStart) shReg <= holdValid ? holdWord : '0;
      else                 shReg <= shReg << 1;
    end
  end

  assign serialOut = shReg[WORD_W-1];
  assign frameSync = fsActive ^ fsPolAct;

  AST_FS_ONE_BIT: assert property (@(posedge clk) disable iff (!rstN)
    (strb.launch && !strb.frameStart) |=> !fsActive);  // R3

  AST_SD_LAUNCH_ONLY: assert property (@(posedge clk) disable iff (!rstN)
    !strb.launch |=> ($stable(serialOut) && $stable(fsActive)));  // R2
endmodule

// File: rtl/aud_tx_clk.sv
module aud_tx_clk
  import aud_tx_pkg::*;
#(
  parameter int WORD_W      = 24,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [3:0]        divSel,
  input  logic              clkDirInt,
  input  logic              bitClkPol,
  input  logic              fsPol,
  input  logic              hfClkPol,
  input  logic              syncMode,
  input  logic [WORD_W-1:0] txData,
  input  logic              txLoad,
  input  logic              sckIn,
  output logic              sckOut,
  output logic              sckOe,
  output logic              frameSync,
  output logic              serialOut,
  output logic              rxShiftEn
);
  txCfg_t    cfgIn;
  txCfg_t    cfgAct;
  txStrobe_t strb;

  assign cfgIn.div    = divSel;
  assign cfgIn.dirInt = clkDirInt;
  assign cfgIn.clkPol = bitClkPol;
  assign cfgIn.fsPol  = fsPol;
  assign cfgIn.hfPol  = hfClkPol;

  aud_tx_ctrl #(
    .WORD_W      (WORD_W),
    .SYNC_STAGES (SYNC_STAGES)
  ) ctrl_i (
    .clk       (clk),
    .rstN      (rstN),
    .cfgIn     (cfgIn),
    .syncMode  (syncMode),
    .sckIn     (sckIn),
    .strb      (strb),
    .cfgAct    (cfgAct),
    .sckOut    (sckOut),
    .sckOe     (sckOe),
    .rxShiftEn (rxShiftEn)
  );

  aud_tx_dpath #(
    .WORD_W (WORD_W)
  ) dpath_i (
    .clk       (clk),
    .rstN      (rstN),
    .strb      (strb),
    .fsPolAct  (cfgAct.fsPol),
    .txData    (txData),
    .txLoad    (txLoad),
    .frameSync (frameSync),
    .serialOut (serialOut)
  );
endmodule

// File: tb/aud_tx_clk_tb.sv
`timescale 1ns/1ps
module aud_tx_clk_tb_top;
  localparam int W = 8;

  logic         clk = 1'b0;
  logic         rstN = 1'b0;
  logic [3:0]   divSel = 4'd0;
  logic         clkDirInt = 1'b0;
  logic         bitClkPol = 1'b0;
  logic         fsPol = 1'b0;
  logic         hfClkPol = 1'b0;
  logic         syncMode = 1'b0;
  logic [W-1:0] txData = '0;
  logic         txLoad = 1'b0;
  logic         sckIn = 1'b0;
  logic         sckOut, sckOe, frameSync, serialOut, rxShiftEn;

  int total = 0;
  int failed = 0;
  bit extRun = 1'b0;
  int extCnt = 0;

  // serial receiver model state
  int           startCnt = 0;
  int           doneCnt = 0;
  int           fsErr = 0;
  int           bitCnt = 0;
  bit           inFrame = 1'b0;
  bit           seenStart = 1'b0;
  logic [W-1:0] acc = '0;
  logic [W-1:0] rxWords [64];
  logic         rxPin = 1'b0;
  logic         rxPrev = 1'b0;

  always #10 clk = ~clk;

  aud_tx_clk #(.WORD_W(W)) dut_i (
    .clk(clk), .rstN(rstN), .divSel(divSel), .clkDirInt(clkDirInt),
    .bitClkPol(bitClkPol), .fsPol(fsPol), .hfClkPol(hfClkPol),
    .syncMode(syncMode), .txData(txData), .txLoad(txLoad), .sckIn(sckIn),
    .sckOut(sckOut), .sckOe(sckOe), .frameSync(frameSync),
    .serialOut(serialOut), .rxShiftEn(rxShiftEn)
  );

  task automatic check(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
    total++;
    if (!ok) begin
      failed++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic finishRun();
    $display("%0d/%0d checks passed", total - failed, total);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    check(1'b0, "WDOG", "watchdog expired", 0, 1);
    finishRun();
  end

  // external bit clock: half period of 6 master cycles
  initial forever begin
    @(posedge clk);
    #5;
    if (extRun) begin
      extCnt++;
      if (extCnt >= 6) begin
        extCnt = 0;
        sckIn = ~sckIn;
      end
    end
  end

  // receiver: samples frame sync and data on the capture edge seen at the pin
  always @(negedge clk) begin
    rxPin = clkDirInt ? sckOut : sckIn;
    if (!rstN) begin
      startCnt = 0; doneCnt = 0; fsErr = 0; bitCnt = 0;
      inFrame = 1'b0; seenStart = 1'b0; acc = '0;
    end else if (bitClkPol ? (rxPin && !rxPrev) : (!rxPin && rxPrev)) begin
      if ((frameSync ^ fsPol) == 1'b1) begin
        if (inFrame) fsErr++;
        startCnt++;
        seenStart = 1'b1;
        inFrame = 1'b1;
        bitCnt = 1;
        acc = {{(W-1){1'b0}}, serialOut};
      end else if (inFrame) begin
        acc = {acc[W-2:0], serialOut};
        bitCnt++;
      end else if (seenStart) begin
        fsErr++;
      end
      if (inFrame && bitCnt == W) begin
        rxWords[startCnt % 64] = acc;
        doneCnt = startCnt;
        inFrame = 1'b0;
      end
    end
    rxPrev = rxPin;
  end

  task automatic doReset();
    @(posedge clk); #5;
    rstN = 1'b0;
    repeat (3) @(posedge clk);
    #5;
    rstN = 1'b1;
  endtask

  // load a word during one frame; expect zeros there, the word next, zeros after
  task automatic sendAndCheck(input logic [W-1:0] word);
    int s0 = startCnt;
    int s;
    while (startCnt == s0) @(negedge clk);
    s = startCnt;
    @(posedge clk); #5;
    txData = word;
    txLoad = 1'b1;
    @(posedge clk); #5;
    txLoad = 1'b0;
    while (doneCnt < s + 2) @(negedge clk);
    check(rxWords[s % 64] == '0, "R9", "frame before load",
          rxWords[s % 64], 0);
    check(rxWords[(s + 1) % 64] == word, "R2 R4", "word after load",
          rxWords[(s + 1) % 64], word);
    check(rxWords[(s + 2) % 64] == '0, "R9", "frame without new word",
          rxWords[(s + 2) % 64], 0);
  endtask

  initial begin
    int cnt;
    bit ok;

    // reset state (R10) and pre-frame configuration (R8)
    fsPol = 1'b1;
    clkDirInt = 1'b0;
    repeat (2) @(negedge clk);
    check(sckOe == 1'b0 && sckOut == 1'b0, "R10", "pin idle in reset", {sckOe, sckOut}, 0);
    check(serialOut == 1'b0 && frameSync == 1'b0, "R10", "sd/fs in reset",
          {serialOut, frameSync}, 0);
    @(posedge clk); #5;
    rstN = 1'b1;
    repeat (2) @(negedge clk);
    check(frameSync == 1'b1, "R8", "fs idle follows input before first frame", frameSync, 1);
    check(serialOut == 1'b0, "R9", "sd zero before any word", serialOut, 0);

    // generated clock phase after reset (R6)
    for (int h = 0; h < 2; h++) begin
      divSel = 4'd15; clkDirInt = 1'b1; hfClkPol = h[0]; fsPol = 1'b0;
      doReset();
      repeat (3) @(negedge clk);
      check(sckOut == h[0], "R6", "generated level after reset", sckOut, h);
      check(sckOe == 1'b1, "R5", "pin driven in internal mode", sckOe, 1);
    end

    // sweep of all divider values with rotating polarities (R1 R2 R3 R4 R9)
    for (int d = 0; d < 16; d++) begin
      divSel = 4'(d); clkDirInt = 1'b1; bitClkPol = d[0];
      fsPol = d[1]; hfClkPol = d[2]; syncMode = 1'b0;
      doReset();
      sendAndCheck(8'(8'h96 + d * 37));
      check(fsErr == 0, "R3", "frame sync placement errors", fsErr, 0);
      while (sckOut !== 1'b0) @(negedge clk);
      while (sckOut !== 1'b1) @(negedge clk);
      cnt = 0;
      while (sckOut === 1'b1) begin @(negedge clk); cnt++; end
      while (sckOut === 1'b0) begin @(negedge clk); cnt++; end
      check(cnt == 2 * (d + 1), "R1", "bit clock period", cnt, 2 * (d + 1));
    end

    // external clock, falling-edge launch (R5 R2)
    divSel = 4'd0; clkDirInt = 1'b0; bitClkPol = 1'b1; fsPol = 1'b0; hfClkPol = 1'b1;
    doReset();
    extRun = 1'b1;
    sendAndCheck(8'hC3);
    check(fsErr == 0, "R3", "frame sync placement external", fsErr, 0);
    check(sckOe == 1'b0 && sckOut == 1'b0, "R5", "pin released in external mode",
          {sckOe, sckOut}, 0);
    extRun = 1'b0;

    // synchronous mode strobes (R7)
    divSel = 4'd1; clkDirInt = 1'b1; bitClkPol = 1'b0; hfClkPol = 1'b0; syncMode = 1'b1;
    doReset();
    repeat (20) @(negedge clk);
    cnt = 0;
    for (int i = 0; i < 40; i++) begin @(negedge clk); cnt += rxShiftEn; end
    check(cnt == 10, "R7", "capture strobes in sync mode", cnt, 10);
    @(posedge clk); #5;
    syncMode = 1'b0;
    @(negedge clk);
    cnt = 0;
    for (int i = 0; i < 40; i++) begin @(negedge clk); cnt += rxShiftEn; end
    check(cnt == 0, "R7", "capture strobes in async mode", cnt, 0);

    // mid-frame control change held until frame boundary (R8)
    divSel = 4'd3; clkDirInt = 1'b1; bitClkPol = 1'b0; fsPol = 1'b0; hfClkPol = 1'b0;
    doReset();
    cnt = startCnt;
    while (startCnt == cnt) @(negedge clk);
    repeat (16) @(negedge clk);
    @(posedge clk); #5;
    fsPol = 1'b1;
    clkDirInt = 1'b0;
    ok = 1'b1;
    for (int i = 0; i < 8; i++) begin
      @(negedge clk);
      if (frameSync !== 1'b0 || sckOe !== 1'b1) ok = 1'b0;
    end
    check(ok, "R8", "controls held mid-frame", ok, 1);
    repeat (72) @(negedge clk);
    check(sckOe == 1'b0 && sckOut == 1'b0, "R8", "direction applied at frame start",
          {sckOe, sckOut}, 0);
    check(frameSync == 1'b0, "R8", "new polarity at frame start, first bit", frameSync, 0);
    extRun = 1'b1;
    repeat (24) @(negedge clk);
    check(frameSync == 1'b1, "R3", "new inactive level after first bit", frameSync, 1);
    extRun = 1'b0;

    finishRun();
  end
endmodule